// File: doc/BRIEF.md
# Correctable Error Counter Threshold Monitor

This block watches the correction side of an ECC-protected memory. Each time the memory repairs a single-bit error, it sends a one-cycle strobe along with the address of the word it fixed. Software can tell the monitor to let these events pass uncounted. It can also have the monitor count them against a programmed limit. When the running total lands on that limit, the monitor sets a pending flag and records the address of the error that caused it. If the interrupt enable is set, it also raises an interrupt.

A small word-addressed register port gives software control over several things: the count enable, the interrupt enable and the limit. Through the same port it can read back the count, the pending flag and the recorded address. A single write-one clear bit resets the total, drops the pending flag and the interrupt, and re-arms address capture. Setting the limit to one gives a per-error alarm that keeps the location of the very first fault. Setting it to zero turns the alarm off while counting goes on.

Top module: `ecc_corr_mon`

## Requirements
- R1: After a synchronous active-low reset, the count, threshold, control bits, pending flag and logged address are all zero, and `irq_o` is low.
- R2: While the count enable (CTRL bit 0) is zero, correctable-error strobes leave the count and the pending flag unchanged.
- R3: While the count enable is one, each strobe raises the count by exactly one. The new value is readable in the cycle after the clock edge that samples the strobe.
- R4: The pending flag (CTRL read bit 3) sets on the edge at which an enabled strobe moves the count to a value equal to a nonzero threshold. `irq_o` is the pending flag gated by the interrupt enable (CTRL bit 1).
- R5: With a threshold of one, the first enabled strobe sets the pending flag and logs that strobe's address.
- R6: The logged address is captured only when the pending flag sets. It is held through later strobes until a clear.
- R7: The count saturates at 2^CNT_W-1, and further strobes leave it there.
- R8: Writing CTRL with bit 2 set clears the count and the pending flag and re-arms capture in the same edge. A clear takes priority over a strobe in the same cycle.
- R9: A threshold of zero never sets the pending flag, however many strobes arrive.
- R10: Register offsets are: 0 CTRL (bit 0 count enable, bit 1 interrupt enable, bit 2 clear, write-only and read as 0, bit 3 pending, read-only), 1 THRESH (low CNT_W bits), 2 COUNT (read-only) and 3 ADDR (read-only). Unused read bits are zero, and reads are combinational on `reg_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_strobe_i | input | 1 | One-cycle corrected-error event |
| err_addr_i | input | ADDR_W | Address of the corrected word |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Maskable threshold interrupt |

## Verification
A strobe or a register write sampled at one clock edge shows up on the ports one edge later. That applies to the count, the pending flag, the logged address and `irq_o`. A read of any register, by contrast, reflects `reg_addr_i` within the same cycle. The bench drives its inputs just after each rising edge and advances a behavioural model on the same rising edge. It compares `irq_o` and the selected read word on the falling edge, so each result is checked in the first cycle it is due. The directed reads follow the same rule, sampling half a cycle after setting the offset.

// File: rtl/ecc_mon_pkg.sv
// Package: shared register offsets and control bit positions for the
// correctable-error monitor. Assumes a 32-bit register data path.
package ecc_mon_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_THR  = 2'd1,
        REG_CNT  = 2'd2,
        REG_ADDR = 2'd3
    } mon_reg_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_CLR_BIT  = 2;
    localparam int CTRL_PEND_BIT = 3;
endpackage

// File: rtl/ecc_mon_regs.sv
// Register file: holds the count enable, the interrupt enable and the
// threshold. Decodes the write-one clear pulse and muxes the read word.
// Assumes CNT_W and ADDR_W are at most 32.
module ecc_mon_regs
    import ecc_mon_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              pend_i,
    input  logic [ADDR_W-1:0] log_addr_i,
    output logic              cnt_en_o,
    output logic              irq_en_o,
    output logic [CNT_W-1:0]  thr_o,
    output logic              clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic ctrl_wr, thr_wr;
    logic unused_wdata;

    assign ctrl_wr      = we_i && (addr_i == REG_CTRL);
    assign thr_wr       = we_i && (addr_i == REG_THR);
    assign clr_o        = ctrl_wr && wdata_i[CTRL_CLR_BIT];
    assign unused_wdata = ^wdata_i;

    // Control bits: updated as a whole by any CTRL write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en_o <= 1'b0;
            irq_en_o <= 1'b0;
        end else if (ctrl_wr) begin
            cnt_en_o <= wdata_i[CTRL_EN_BIT];
            irq_en_o <= wdata_i[CTRL_IE_BIT];
        end
    end

    // Threshold register: keeps the low CNT_W bits of a THRESH write.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_o <= '0;
        else if (thr_wr) thr_o <= wdata_i[CNT_W-1:0];
    end

    // Read mux: zero-extends each field to the data width.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_CTRL: begin
                rdata_o[CTRL_EN_BIT]   = cnt_en_o;
                rdata_o[CTRL_IE_BIT]   = irq_en_o;
                rdata_o[CTRL_PEND_BIT] = pend_i;
            end
            REG_THR:  rdata_o = DATA_W'(thr_o);
            REG_CNT:  rdata_o = DATA_W'(cnt_i);
            default:  rdata_o = DATA_W'(log_addr_i);
        endcase
    end
endmodule

// File: rtl/ecc_mon_counter.sv
// Saturating event counter: counts enabled strobes. It flags the edge at
// which the count steps onto a nonzero threshold. Assumes clear overrides
// the increment.
module ecc_mon_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             at_max;
    logic [CNT_W-1:0] cnt_nxt;

    assign at_max  = (cnt_o == CNT_MAX);
    assign cnt_nxt = cnt_o + CNT_W'(1);
    assign hit_o   = inc_i && !at_max && (cnt_nxt == thr_i) && (thr_i != '0);

    // Count register: clear first, then a non-wrapping increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_o <= '0;
        else if (clr_i)             cnt_o <= '0;
        else if (inc_i && !at_max)  cnt_o <= cnt_nxt;
    end
endmodule

// File: rtl/ecc_mon_capture.sv
// Threshold capture: sets the pending flag on the first hit and stores
// the address presented with it. Holds both until clear.
module ecc_mon_capture #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic              clr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              pend_o,
    output logic [ADDR_W-1:0] log_addr_o
);
    // Pending flag and address log: armed only while the flag is clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o     <= 1'b0;
            log_addr_o <= '0;
        end else if (clr_i) begin
            pend_o     <= 1'b0;
        end else if (hit_i && !pend_o) begin
            pend_o     <= 1'b1;
            log_addr_o <= addr_i;
        end
    end
endmodule

// File: rtl/ecc_corr_mon.sv
// Top: counts corrected-error strobes against a programmable threshold.
// It raises a maskable interrupt and logs the address of the crossing
// error. Assumes each strobe lasts one cycle.
module ecc_corr_mon
    import ecc_mon_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_strobe_i,
    input  logic [ADDR_W-1:0] err_addr_i,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic              cnt_en, irq_en, clr_pulse, hit, pend_q;
    logic [CNT_W-1:0]  thr_q, cnt_q;
    logic [ADDR_W-1:0] log_addr_q;

    ecc_mon_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .cnt_i(cnt_q), .pend_i(pend_q),
        .log_addr_i(log_addr_q), .cnt_en_o(cnt_en), .irq_en_o(irq_en),
        .thr_o(thr_q), .clr_o(clr_pulse), .rdata_o(reg_rdata_o)
    );

    ecc_mon_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .inc_i(err_strobe_i && cnt_en),
        .clr_i(clr_pulse), .thr_i(thr_q), .cnt_o(cnt_q), .hit_o(hit)
    );

    ecc_mon_capture #(.ADDR_W(ADDR_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(clr_pulse),
        .addr_i(err_addr_i), .pend_o(pend_q), .log_addr_o(log_addr_q)
    );

    assign irq_o = pend_q && irq_en;
endmodule

// File: rtl/ecc_corr_mon_chk.sv
// Checker: temporal properties of the monitor's internal state, bound
// into the top module.
module ecc_corr_mon_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              count_en,
    input logic              irq_en,
    input logic [CNT_W-1:0]  thr,
    input logic [CNT_W-1:0]  cnt,
    input logic              pend,
    input logic [ADDR_W-1:0] log_addr,
    input logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clr) |=> ($stable(cnt) && $stable(pend)));
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));
    a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> (pend && $stable(log_addr)));
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !pend));
    a_r9_zero_thr: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == '0 && !pend) |=> !pend);
endmodule

bind ecc_corr_mon ecc_corr_mon_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .count_en(cnt_en),
    .irq_en(irq_en), .thr(thr_q), .cnt(cnt_q), .pend(pend_q),
    .log_addr(log_addr_q), .irq(irq_o)
);

// File: tb/ecc_corr_mon_tb_top.sv
module ecc_corr_mon_tb_top;
    localparam int CW = 6;
    localparam int AW = 16;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe = 1'b0;
    logic [AW-1:0] eaddr = '0;
    logic          we = 1'b0;
    logic [1:0]    raddr = 2'd0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // behavioural reference state
    bit        m_en, m_ie, m_pend;
    int        m_thr, m_cnt;
    int        m_addr;

    ecc_corr_mon #(.CNT_W(CW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .err_strobe_i(strobe), .err_addr_i(eaddr),
        .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    always #2 clk = ~clk;

    // reference model advances on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_pend = 0; m_thr = 0; m_cnt = 0; m_addr = 0;
        end else begin
            bit clr, inc, hit;
            clr = we && raddr == 2'd0 && wdata[2];
            inc = strobe && m_en;
            hit = inc && m_cnt < MAXC && m_thr != 0 && m_cnt + 1 == m_thr;
            if (clr) m_cnt = 0;
            else if (inc && m_cnt < MAXC) m_cnt = m_cnt + 1;
            if (clr) m_pend = 0;
            else if (hit && !m_pend) begin m_pend = 1; m_addr = int'(eaddr); end
            if (we && raddr == 2'd0) begin m_en = wdata[0]; m_ie = wdata[1]; end
            if (we && raddr == 2'd1) m_thr = int'(wdata) & MAXC;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: exp_rd = {28'd0, m_pend, 1'b0, m_ie, m_en};
            2'd1: exp_rd = 32'(m_thr);
            2'd2: exp_rd = 32'(m_cnt);
            default: exp_rd = 32'(m_addr);
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 irq", {31'd0, irq}, {31'd0, m_pend && m_ie});
            chk(raddr == 2'd2 ? "R3 count" : raddr == 2'd3 ? "R6 addr" : "R10 read",
                rdata, exp_rd(raddr));
        end
    end

    task automatic idle();
        @(posedge clk); #1;
        strobe = 0; we = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        strobe = 0; we = 1; raddr = a; wdata = d;
        @(posedge clk); #1;
        we = 0;
    endtask

    task automatic hit(input logic [AW-1:0] a, input logic [1:0] view);
        @(posedge clk); #1;
        we = 0; strobe = 1; eaddr = a; raddr = view;
        @(posedge clk); #1;
        strobe = 0;
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [31:0] exp);
        @(posedge clk); #1;
        we = 0; strobe = 0; raddr = a;
        @(negedge clk);
        chk(req, rdata, exp);
    endtask

    initial begin
        #200000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd(2'd0, "R1 ctrl", 32'd0);
        rd(2'd1, "R1 thr", 32'd0);
        rd(2'd2, "R1 count", 32'd0);
        rd(2'd3, "R1 addr", 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        // R2 disabled counting ignores strobes
        wr(2'd1, 32'd1);
        hit(16'h1111, 2'd2); hit(16'h2222, 2'd2);
        rd(2'd2, "R2 count", 32'd0);
        rd(2'd0, "R2 pend", 32'd0);
        // R5 threshold one, first error logged
        wr(2'd0, 32'h3);
        hit(16'hA5A5, 2'd3);
        rd(2'd3, "R5 addr", 32'hA5A5);
        chk("R5 irq", {31'd0, irq}, 32'd1);
        // R6 later strobes keep the log; R3 count steps
        hit(16'h0BAD, 2'd2); hit(16'h0C0D, 2'd3);
        rd(2'd3, "R6 addr", 32'hA5A5);
        rd(2'd2, "R3 count", 32'd3);
        // R8 clear, then clear together with a strobe
        wr(2'd0, 32'h7);
        chk("R8 irq", {31'd0, irq}, 32'd0);
        rd(2'd2, "R8 count", 32'd0);
        @(posedge clk); #1;
        we = 1; raddr = 2'd0; wdata = 32'h7; strobe = 1; eaddr = 16'h7777;
        idle();
        rd(2'd0, "R8 same cycle", 32'h3);
        rd(2'd2, "R8 same cycle count", 32'd0);
        // R4 threshold three with interrupt masked
        wr(2'd1, 32'd3);
        wr(2'd0, 32'h5);
        hit(16'h0001, 2'd0); hit(16'h0002, 2'd0);
        rd(2'd0, "R4 not yet", 32'h1);
        hit(16'h0003, 2'd0);
        rd(2'd0, "R4 pend masked", 32'h9);
        chk("R4 masked irq", {31'd0, irq}, 32'd0);
        wr(2'd0, 32'h3);
        chk("R4 unmasked irq", {31'd0, irq}, 32'd1);
        rd(2'd3, "R4 addr", 32'h0003);
        // R9 zero threshold, R7 saturation
        wr(2'd0, 32'h7);
        wr(2'd1, 32'hFFFF_FFC0);
        rd(2'd1, "R10 thr mask", 32'd0);
        for (int i = 0; i < MAXC + 6; i++) hit(AW'(i), 2'd2);
        rd(2'd2, "R7 saturated", 32'(MAXC));
        rd(2'd0, "R9 no pend", 32'h3);
        chk("R9 irq", {31'd0, irq}, 32'd0);
        // R7 threshold at max unreachable after saturation
        wr(2'd1, 32'(MAXC));
        hit(16'h4444, 2'd0);
        rd(2'd0, "R7 no rehit", 32'h3);
        // R10 unused ctrl bits read zero
        wr(2'd0, 32'hFFFF_FFF8);
        rd(2'd0, "R10 ctrl", 32'h0);
        idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule